// File: doc/BRIEF.md
# Core Low-Power Handshake Sequencer

This block sits on the device side of a processor core and turns the core's low-power request levels into a staged shutdown. The core raises one of three request levels: light (doze), medium (nap) or deep (sleep). It raises a level only when its wait-enable state bit and the matching per-mode enable bit are both set. The sequencer first asks the core to stop fetching instructions and waits for the core to report that execution has stopped. For the two deeper modes it then asks the core to stop its clock distribution and waits for that to be confirmed. In the deepest mode it also switches off the core's time base.

The way back runs in reverse order. A wake starts when the request level falls or when a wake event input is high. The block first withdraws the clock-stop request and waits for the stopped acknowledge to clear. It then withdraws the halt request and waits for the halted acknowledge to clear, and only then returns to the running state. Every acknowledge wait is guarded by a cycle counter. If an acknowledge is late, the block raises a sticky error flag and freezes where it stands until reset.

Top module: `core_pwr_seq`

## Requirements
- R1: After synchronous reset, state_o is RUN (0), halt_req and stop_req are 0, tb_en is 1 and err_o is 0.
- R2: From RUN, with wake_evt low, any request level raises halt_req and moves state_o to HALTING (1). The acknowledge ports do not matter for this step.
- R3: stop_req rises only in the cycle after halted_ack was seen high while HALTING. stop_req is never high while halt_req is low.
- R4: A doze-only request (request bits doze=bit0, nap=bit1, sleep=bit2, i.e. 3'b001) settles in HALTED (2) with stop_req 0 and tb_en 1.
- R5: A nap request settles in STOPPED (4) with stop_req 1 and tb_en 1.
- R6: A sleep request settles in STOPPED with tb_en 0. tb_en is low only while stop_req is high.
- R7: When several request levels are high, the deepest one is served: sleep over nap over doze. The mode is latched on leaving RUN.
- R8: When the request falls or wake_evt is high, the state goes to WAKING (5), stop_req drops and tb_en returns to 1. halt_req stays high until stopped_ack is low. The state returns to RUN only after halt_req is low and halted_ack is low.
- R9: While wake_evt is high, no new shutdown starts from RUN.
- R10: If an acknowledge wait lasts TMO_CYC cycles with no progress, err_o rises. From then on err_o stays high and every output holds its value until reset.
- R11: STOPPING (3) is reported while stop_req is high and stopped_ack is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| doze_rq | input | 1 | Light low-power request level from core |
| nap_rq | input | 1 | Medium low-power request level from core |
| sleep_rq | input | 1 | Deep low-power request level from core |
| wake_evt | input | 1 | Wake event; forces the wake-up sequence |
| halted_ack | input | 1 | Core reports instruction execution stopped |
| stopped_ack | input | 1 | Core reports clock distribution stopped |
| halt_req | output | 1 | Request to stop instruction fetch |
| stop_req | output | 1 | Request to stop clock distribution |
| tb_en | output | 1 | Time-base enable; low disables the time base |
| state_o | output | 3 | Current sequencer state code |
| err_o | output | 1 | Sticky acknowledge-timeout flag |

## Verification
All seven non-zero combinations of the three request bits are applied against a core model that acknowledges after a short delay. The single-bit patterns show how deep each mode goes and what it does to the time base. The multi-bit patterns show that the deepest level wins. Directed runs hold the acknowledges by hand, so each intermediate state can be seen and the order of halt and stop on the way down and back can be told apart. A withheld acknowledge shows the timeout and the freeze. A held wake event with the request still high shows that the wake input alone is enough to bring the core back and keep it running.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_HALTING  = 3'd1,
    ST_HALTED   = 3'd2,
    ST_STOPPING = 3'd3,
    ST_STOPPED  = 3'd4,
    ST_WAKING   = 3'd5
  } pwr_state_e;

  typedef enum logic [1:0] {
    MD_NONE  = 2'd0,
    MD_DOZE  = 2'd1,
    MD_NAP   = 2'd2,
    MD_SLEEP = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/core_pwr_mode_pick.sv
module core_pwr_mode_pick
  import core_pwr_pkg::*;
(
  input  logic      doze_rq,
  input  logic      nap_rq,
  input  logic      sleep_rq,
  output pwr_mode_e mode,
  output logic      any_rq
);
  always_comb begin
    if (sleep_rq)     mode = MD_SLEEP;
    else if (nap_rq)  mode = MD_NAP;
    else if (doze_rq) mode = MD_DOZE;
    else              mode = MD_NONE;
  end
  assign any_rq = doze_rq | nap_rq | sleep_rq;
endmodule

// File: rtl/core_pwr_ack_timer.sv
module core_pwr_ack_timer #(
  parameter int TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/core_pwr_fsm.sv
module core_pwr_fsm
  import core_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwr_mode_e  sel_mode,
  input  logic       any_rq,
  input  logic       wake_evt,
  input  logic       halted_ack,
  input  logic       stopped_ack,
  input  logic       tmo_hit,
  output logic       wait_run,
  output logic       halt_req,
  output logic       stop_req,
  output logic       tb_en,
  output pwr_state_e state,
  output logic       err
);
  pwr_mode_e mode_q;
  logic      abort;
  logic      waiting;
  logic      progress;

  assign abort = !any_rq || wake_evt;

  always_comb begin
    waiting  = 1'b0;
    progress = 1'b0;
    case (state)
      ST_HALTING:  begin waiting = 1'b1; progress = abort || halted_ack;  end
      ST_STOPPING: begin waiting = 1'b1; progress = abort || stopped_ack; end
      ST_WAKING:   begin
        waiting  = 1'b1;
        progress = halt_req ? !stopped_ack : !halted_ack;
      end
      default: ;
    endcase
  end

  assign wait_run = waiting && !progress && !err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      mode_q   <= MD_NONE;
      halt_req <= 1'b0;
      stop_req <= 1'b0;
      tb_en    <= 1'b1;
      err      <= 1'b0;
    end else if (!err) begin
      if (tmo_hit) begin
        err <= 1'b1;
      end else begin
        case (state)
          ST_RUN: begin
            if (!abort) begin
              state    <= ST_HALTING;
              mode_q   <= sel_mode;
              halt_req <= 1'b1;
            end
          end
          ST_HALTING: begin
            if (abort) begin
              state <= ST_WAKING;
            end else if (halted_ack) begin
              if (mode_q == MD_DOZE) begin
                state <= ST_HALTED;
              end else begin
                state    <= ST_STOPPING;
                stop_req <= 1'b1;
              end
            end
          end
          ST_HALTED: begin
            if (abort) state <= ST_WAKING;
          end
          ST_STOPPING: begin
            if (abort) begin
              state    <= ST_WAKING;
              stop_req <= 1'b0;
            end else if (stopped_ack) begin
              state <= ST_STOPPED;
              if (mode_q == MD_SLEEP) tb_en <= 1'b0;
            end
          end
          ST_STOPPED: begin
            if (abort) begin
              state    <= ST_WAKING;
              stop_req <= 1'b0;
              tb_en    <= 1'b1;
            end
          end
          ST_WAKING: begin
            if (halt_req) begin
              if (!stopped_ack) halt_req <= 1'b0;
            end else if (!halted_ack) begin
              state <= ST_RUN;
            end
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_pkg::*;
#(
  parameter int TMO_CYC = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       doze_rq,
  input  logic       nap_rq,
  input  logic       sleep_rq,
  input  logic       wake_evt,
  input  logic       halted_ack,
  input  logic       stopped_ack,
  output logic       halt_req,
  output logic       stop_req,
  output logic       tb_en,
  output logic [2:0] state_o,
  output logic       err_o
);
  pwr_mode_e  sel_mode;
  pwr_state_e st;
  logic       any_rq;
  logic       wait_run;
  logic       tmo_hit;

  core_pwr_mode_pick u_pick (
    .doze_rq  (doze_rq),
    .nap_rq   (nap_rq),
    .sleep_rq (sleep_rq),
    .mode     (sel_mode),
    .any_rq   (any_rq)
  );

  core_pwr_ack_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (wait_run),
    .expired (tmo_hit)
  );

  core_pwr_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sel_mode    (sel_mode),
    .any_rq      (any_rq),
    .wake_evt    (wake_evt),
    .halted_ack  (halted_ack),
    .stopped_ack (stopped_ack),
    .tmo_hit     (tmo_hit),
    .wait_run    (wait_run),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .tb_en       (tb_en),
    .state       (st),
    .err         (err_o)
  );

  assign state_o = st;
endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       halted_ack,
  input logic       stopped_ack,
  input logic       halt_req,
  input logic       stop_req,
  input logic       tb_en,
  input logic [2:0] state_o,
  input logic       err_o
);
  assert_stop_after_halt_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_req) |-> $past(halted_ack) && $past(state_o) == 3'd1);

  assert_stop_needs_halt_R3: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> halt_req);

  assert_tb_only_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    !tb_en |-> stop_req && state_o == 3'd4);

  assert_halt_drop_order_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(halt_req) |-> !$past(stopped_ack) && !stop_req);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |=> $stable(state_o) && $stable(halt_req) && $stable(stop_req));

  assert_state_legal_R11: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd5);
endmodule

bind core_pwr_seq core_pwr_seq_chk u_chk (.*);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic doze_rq = 0, nap_rq = 0, sleep_rq = 0, wake_evt = 0;
  logic model_on = 1'b1;
  logic man_h = 0, man_s = 0;
  logic [1:0] hp = '0, sp = '0;
  logic mh = 0, ms = 0;
  logic halted_ack, stopped_ack;
  logic halt_req, stop_req, tb_en, err_o;
  logic [2:0] state_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign halted_ack  = model_on ? mh : man_h;
  assign stopped_ack = model_on ? ms : man_s;

  always @(negedge clk) begin
    hp <= {hp[0], halt_req};
    sp <= {sp[0], stop_req};
    mh <= hp[1];
    ms <= sp[1];
  end

  core_pwr_seq #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .doze_rq(doze_rq), .nap_rq(nap_rq), .sleep_rq(sleep_rq),
    .wake_evt(wake_evt), .halted_ack(halted_ack), .stopped_ack(stopped_ack),
    .halt_req(halt_req), .stop_req(stop_req), .tb_en(tb_en),
    .state_o(state_o), .err_o(err_o)
  );

  // {req[2:0] (sleep,nap,doze), settled state, stop_req, tb_en}
  localparam logic [7:0] VEC [7] = '{
    {3'b001, 3'd2, 1'b0, 1'b1},
    {3'b010, 3'd4, 1'b1, 1'b1},
    {3'b100, 3'd4, 1'b1, 1'b0},
    {3'b011, 3'd4, 1'b1, 1'b1},
    {3'b101, 3'd4, 1'b1, 1'b0},
    {3'b110, 3'd4, 1'b1, 1'b0},
    {3'b111, 3'd4, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_rq(input logic [2:0] r);
    {sleep_rq, nap_rq, doze_rq} = r;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 halt_req", halt_req, 0);
    chk("R1 stop_req", stop_req, 0);
    chk("R1 tb_en", tb_en, 1);
    chk("R1 err", err_o, 0);

    // Table walk: R4 R5 R6 R7 and return R8
    for (int i = 0; i < 7; i++) begin
      set_rq(VEC[i][7:5]);
      cyc(20);
      chk($sformatf("R7 vec%0d state", i), state_o, int'(VEC[i][4:2]));
      chk($sformatf("R4/R5 vec%0d halt", i), halt_req, 1);
      chk($sformatf("R5 vec%0d stop", i), stop_req, int'(VEC[i][1]));
      chk($sformatf("R6 vec%0d tb_en", i), tb_en, int'(VEC[i][0]));
      set_rq(3'b000);
      cyc(20);
      chk($sformatf("R8 vec%0d back state", i), state_o, 0);
      chk($sformatf("R8 vec%0d back halt", i), halt_req, 0);
      chk($sformatf("R8 vec%0d back tb", i), tb_en, 1);
      chk($sformatf("R10 vec%0d no err", i), err_o, 0);
    end

    // Manual acknowledges: ordering down and back
    model_on = 1'b0;
    man_h = 0; man_s = 0;
    set_rq(3'b010);
    cyc(4);
    chk("R2 halting state", state_o, 1);
    chk("R2 halt_req", halt_req, 1);
    chk("R3 no stop before halted", stop_req, 0);
    man_h = 1;
    cyc(2);
    chk("R11 stopping state", state_o, 3);
    chk("R3 stop after halted", stop_req, 1);
    man_s = 1;
    cyc(2);
    chk("R5 stopped state", state_o, 4);
    set_rq(3'b000);
    cyc(2);
    chk("R8 waking state", state_o, 5);
    chk("R8 stop dropped", stop_req, 0);
    cyc(3);
    chk("R8 halt held while stopped", halt_req, 1);
    man_s = 0;
    cyc(2);
    chk("R8 halt dropped", halt_req, 0);
    chk("R8 waits halted clear", state_o, 5);
    man_h = 0;
    cyc(2);
    chk("R8 run again", state_o, 0);

    // Timeout and freeze
    set_rq(3'b001);
    cyc(TMO + 5);
    chk("R10 err raised", err_o, 1);
    chk("R10 held in halting", state_o, 1);
    set_rq(3'b000);
    cyc(4);
    chk("R10 frozen state", state_o, 1);
    chk("R10 frozen halt", halt_req, 1);
    chk("R10 err sticky", err_o, 1);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk("R1 err cleared by reset", err_o, 0);
    chk("R1 state after reset", state_o, 0);

    // Wake event with request still high
    model_on = 1'b1;
    cyc(4);
    set_rq(3'b100);
    cyc(20);
    chk("R6 sleep tb off", tb_en, 0);
    wake_evt = 1'b1;
    cyc(20);
    chk("R8 wake_evt returns run", state_o, 0);
    chk("R9 no re-entry halt", halt_req, 0);
    chk("R8 wake tb on", tb_en, 1);
    set_rq(3'b000);
    wake_evt = 1'b0;
    cyc(4);
    chk("R10 no err after wake", err_o, 0);

    finish_run();
  end
endmodule